// File: doc/BRIEF.md
# Multiplexed Bus Slave Interface

This block is the slave end of a 32-bit multiplexed address/data bus in the style of common 8086-family peripherals. The bus master first places an address on the shared AD lines and pulses ALE. It then asserts chip select, a byte-enable pattern and either the read or the write strobe. Only the low eight AD lines carry address information into the block. The address is latched while ALE is high. The byte-enable pattern, taken together with address bit 0, is decoded into a set of active byte lanes and an access width.

Each address falls into one of three target classes. Ordinary registers accept only byte accesses. The counter port accepts byte or 16-bit accesses. The FIFO data port also accepts 32-bit accesses. A legal read drives only the selected byte lanes of the outgoing data and leaves the other lanes' drive enables off. Any pattern outside the decode table, a width that the target does not accept, or read and write asserted together counts as no access and sets a sticky error flag. All bus inputs pass through a two-stage synchronizer. A legal strobe produces a single-cycle read or write pulse toward the core. The pad tristate buffers, the FIFO storage and the register contents live outside this block.

Top module: `mbs_slave`

## Requirements
- R1: The access address `acc_addr` is the value seen on `ad_lo_i` while ALE was last high. Changes on `ad_lo_i` after ALE falls do not alter it.
- R2: When ALE and a read strobe reach the block in the same synchronized cycle, the access is decoded with the new address and not with the previously latched one.
- R3: With all four byte enables high (`be_n` = 4'b1111), a strobe produces no pulse, leaves `ad_oe` at 0 and does not set the error flag.
- R4: Byte accesses decode as follows. `be_n` 1110 with A0=0 gives lanes 4'b0001. `be_n` 1101 with A0=1 gives 4'b0010. `be_n` 1011 with A0=0 gives 4'b0100. `be_n` 0111 with A0=1 gives 4'b1000. Lane n is AD[8n+7:8n].
- R5: Wider accesses require A0=0. `be_n` 1100 gives lanes 4'b0011 and `be_n` 0011 gives lanes 4'b1100, both 16 bits wide. `be_n` 0000 gives lanes 4'b1111, which is 32 bits wide.
- R6: Any other `be_n`/A0 combination produces no pulse, leaves `acc_lanes` and `ad_oe` at 0, and sets `err_o`. `err_o` stays set until reset.
- R7: `acc_tgt` is 2'b01 (FIFO) for addresses 0x80–0x83, 2'b10 (counter) for 0x84–0x87, and 2'b00 (register) otherwise. Registers accept only 8-bit accesses, the counter accepts 8- or 16-bit accesses and the FIFO accepts all three widths. Any other width behaves as R6.
- R8: During a legal read, `ad_oe` equals the decoded lanes from the cycle after the read pulse. It clears three clocks after chip select and read are released. `ad_o` carries `rdata_i` on the enabled lanes and zero on the others.
- R9: Each legal strobe gives exactly one single-cycle `rd_pulse` or `wr_pulse`. The pulse is visible after the second rising clock edge following the strobe assertion. A write never drives `ad_oe`.
- R10: Read and write asserted together produce no pulse and set `err_o`.
- R11: While reset is held and right after it, `ad_oe`, `err_o`, `rd_pulse` and `wr_pulse` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address latch strobe, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| be_n | input | 4 | Byte enables, active low |
| ad_lo_i | input | 8 | Low AD lines, used for the address |
| rdata_i | input | 32 | Read data from the addressed target |
| ad_o | output | 32 | Outgoing data toward the AD pads |
| ad_oe | output | 4 | Per-lane pad drive enable |
| rd_pulse | output | 1 | Single-cycle read request to the core |
| wr_pulse | output | 1 | Single-cycle write request to the core |
| acc_addr | output | 8 | Address of the current access |
| acc_lanes | output | 4 | Decoded byte lanes, zero when illegal |
| acc_tgt | output | 2 | Target class of the address |
| err_o | output | 1 | Sticky illegal-access flag |

## Verification
Address capture and strobe decoding can fall in the same synchronized cycle. In that case the block must choose the fresh address over the one it latched earlier. The bench first leaves a register address latched. It then raises ALE carrying a counter address and asserts the read strobe with a 16-bit pattern, all on the same edge. A decode against the stale register address would reject the 16-bit width. The bench therefore expects a read pulse, the counter target and lanes 4'b0011, and these results can only come from the new address.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    localparam int LANES  = 4;
    localparam int DATA_W = LANES * 8;

    typedef enum logic [1:0] {
        TGT_REG  = 2'b00,
        TGT_FIFO = 2'b01,
        TGT_CNT  = 2'b10
    } tgt_e;

    typedef enum logic [1:0] {
        W_NONE = 2'b00,
        W8     = 2'b01,
        W16    = 2'b10,
        W32    = 2'b11
    } width_e;

    typedef struct packed {
        logic             idle;
        logic             legal;
        logic [LANES-1:0] lanes;
        width_e           width;
    } lane_sel_t;

    // Fixed byte-enable / A0 decode table.
    function automatic lane_sel_t decode_lanes(input logic [LANES-1:0] be_n, input logic a0);
        lane_sel_t s;
        s.idle  = 1'b0;
        s.legal = 1'b1;
        s.lanes = '0;
        s.width = W_NONE;
        unique casez ({be_n, a0})
            5'b1111_?: begin s.idle = 1'b1; s.legal = 1'b0; end
            5'b1110_0: begin s.lanes = 4'b0001; s.width = W8;  end
            5'b1101_1: begin s.lanes = 4'b0010; s.width = W8;  end
            5'b1011_0: begin s.lanes = 4'b0100; s.width = W8;  end
            5'b0111_1: begin s.lanes = 4'b1000; s.width = W8;  end
            5'b1100_0: begin s.lanes = 4'b0011; s.width = W16; end
            5'b0011_0: begin s.lanes = 4'b1100; s.width = W16; end
            5'b0000_0: begin s.lanes = 4'b1111; s.width = W32; end
            default:   begin s.legal = 1'b0; end
        endcase
        return s;
    endfunction

    function automatic logic width_ok(input tgt_e t, input width_e w);
        logic ok;
        unique case (t)
            TGT_FIFO: ok = (w == W8) || (w == W16) || (w == W32);
            TGT_CNT:  ok = (w == W8) || (w == W16);
            default:  ok = (w == W8);
        endcase
        return ok;
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] lanes);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[i*8 +: 8] = {8{lanes[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/mbs_sync.sv
module mbs_sync #(
    parameter int              W       = 8,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= RST_VAL;
                    else     stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= RST_VAL;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/mbs_addr_latch.sv
module mbs_addr_latch #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ale_s,
    input  logic [AW-1:0] ad_s,
    output logic [AW-1:0] addr_eff
);

    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst)        addr_q <= '0;
        else if (ale_s) addr_q <= ad_s;
    end

    // Bypass so that a strobe coinciding with ALE sees the fresh address.
    assign addr_eff = ale_s ? ad_s : addr_q;

endmodule

// File: rtl/mbs_target_dec.sv
module mbs_target_dec
    import mbs_pkg::*;
#(
    parameter int          AW        = 8,
    parameter logic [AW-1:0] FIFO_ADDR = 8'h80,
    parameter logic [AW-1:0] CNT_ADDR  = 8'h84,
    parameter logic [AW-1:0] PORT_MASK = 8'hFC
) (
    input  logic [AW-1:0] addr,
    output tgt_e          tgt
);

    localparam logic [AW-1:0] FIFO_KEY = FIFO_ADDR & PORT_MASK;
    localparam logic [AW-1:0] CNT_KEY  = CNT_ADDR & PORT_MASK;

    logic [AW-1:0] key;

    always_comb begin
        key = addr & PORT_MASK;
        if (key == FIFO_KEY)     tgt = TGT_FIFO;
        else if (key == CNT_KEY) tgt = TGT_CNT;
        else                     tgt = TGT_REG;
    end

endmodule

// File: rtl/mbs_slave.sv
module mbs_slave
    import mbs_pkg::*;
#(
    parameter int            AW          = 8,
    parameter int            SYNC_STAGES = 2,
    parameter logic [AW-1:0] FIFO_ADDR   = 8'h80,
    parameter logic [AW-1:0] CNT_ADDR    = 8'h84,
    parameter logic [AW-1:0] PORT_MASK   = 8'hFC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ale,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [LANES-1:0]  be_n,
    input  logic [AW-1:0]     ad_lo_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] ad_o,
    output logic [LANES-1:0]  ad_oe,
    output logic              rd_pulse,
    output logic              wr_pulse,
    output logic [AW-1:0]     acc_addr,
    output logic [LANES-1:0]  acc_lanes,
    output logic [1:0]        acc_tgt,
    output logic              err_o
);

    localparam int SW = 4 + LANES + AW;
    localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, 1'b1, 1'b1, {LANES{1'b1}}, {AW{1'b0}}};

    logic [SW-1:0]    raw_v, syn_v;
    logic             ale_s, cs_n_s, rd_n_s, wr_n_s;
    logic [LANES-1:0] be_n_s;
    logic [AW-1:0]    ad_s, addr_eff;
    tgt_e             tgt;
    lane_sel_t        sel;

    logic rd_req, wr_req, strb, strb_q, start, ok, rd_drive;
    logic [LANES-1:0]  oe_nxt, oe_q;
    logic [DATA_W-1:0] ad_q;
    logic              err_q;

    assign raw_v = {ale, cs_n, rd_n, wr_n, be_n, ad_lo_i};

    mbs_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_v),
        .q   (syn_v)
    );

    assign {ale_s, cs_n_s, rd_n_s, wr_n_s, be_n_s, ad_s} = syn_v;

    mbs_addr_latch #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .ale_s    (ale_s),
        .ad_s     (ad_s),
        .addr_eff (addr_eff)
    );

    mbs_target_dec #(
        .AW(AW), .FIFO_ADDR(FIFO_ADDR), .CNT_ADDR(CNT_ADDR), .PORT_MASK(PORT_MASK)
    ) u_tgt (
        .addr (addr_eff),
        .tgt  (tgt)
    );

    always_comb begin
        sel      = decode_lanes(be_n_s, addr_eff[0]);
        rd_req   = !cs_n_s && !rd_n_s;
        wr_req   = !cs_n_s && !wr_n_s;
        strb     = rd_req || wr_req;
        start    = strb && !strb_q;
        ok       = sel.legal && width_ok(tgt, sel.width) && !(rd_req && wr_req);
        rd_drive = rd_req && !wr_req && ok;
        oe_nxt   = rd_drive ? sel.lanes : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strb_q <= 1'b0;
            oe_q   <= '0;
            ad_q   <= '0;
            err_q  <= 1'b0;
        end else begin
            strb_q <= strb;
            oe_q   <= oe_nxt;
            ad_q   <= rdata_i & lane_mask(oe_nxt);
            if (start && !sel.idle && !ok) err_q <= 1'b1;
        end
    end

    assign rd_pulse  = start && rd_drive;
    assign wr_pulse  = start && wr_req && !rd_req && ok;
    assign acc_addr  = addr_eff;
    assign acc_lanes = ok ? sel.lanes : '0;
    assign acc_tgt   = tgt;
    assign ad_oe     = oe_q;
    assign ad_o      = ad_q;
    assign err_o     = err_q;

endmodule

// File: rtl/mbs_slave_chk.sv
module mbs_slave_chk #(
    parameter int LN = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_pulse,
    input logic          wr_pulse,
    input logic          err_o,
    input logic          rd_drive,
    input logic [LN-1:0] ad_oe,
    input logic [LN-1:0] acc_lanes
);

    a_r9_rd_single: assert property (@(posedge clk) disable iff (rst)
        rd_pulse |=> !rd_pulse);

    a_r9_wr_single: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> !wr_pulse);

    a_r10_no_dual_pulse: assert property (@(posedge clk) disable iff (rst)
        !(rd_pulse && wr_pulse));

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    a_r8_oe_needs_read: assert property (@(posedge clk) disable iff (rst)
        !rd_drive |=> (ad_oe == '0));

    a_r5_lane_shape: assert property (@(posedge clk) disable iff (rst)
        rd_pulse |-> ($countones(acc_lanes) == 1 || $countones(acc_lanes) == 2
                      || $countones(acc_lanes) == 4));

endmodule

bind mbs_slave mbs_slave_chk #(.LN(4)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_pulse  (rd_pulse),
    .wr_pulse  (wr_pulse),
    .err_o     (err_o),
    .rd_drive  (rd_drive),
    .ad_oe     (ad_oe),
    .acc_lanes (acc_lanes)
);

// File: tb/mbs_slave_test.sv
module mbs_slave_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ale = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [3:0]  be_n = 4'hF;
    logic [7:0]  ad_lo_i = '0;
    logic [31:0] rdata_i = 32'h1122_3344;
    logic [31:0] ad_o;
    logic [3:0]  ad_oe, acc_lanes;
    logic        rd_pulse, wr_pulse, err_o;
    logic [7:0]  acc_addr;
    logic [1:0]  acc_tgt;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    bit err_exp = 0;

    always #2.5 clk = ~clk;

    mbs_slave uut (
        .clk(clk), .rst(rst), .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .be_n(be_n), .ad_lo_i(ad_lo_i), .rdata_i(rdata_i), .ad_o(ad_o), .ad_oe(ad_oe),
        .rd_pulse(rd_pulse), .wr_pulse(wr_pulse), .acc_addr(acc_addr),
        .acc_lanes(acc_lanes), .acc_tgt(acc_tgt), .err_o(err_o)
    );

    // {addr, be_n, ok, lanes, tgt}
    typedef struct packed {
        logic [7:0] addr;
        logic [3:0] be;
        logic       ok;
        logic [3:0] lanes;
        logic [1:0] tgt;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{8'h10, 4'b1110, 1'b1, 4'b0001, 2'b00},  // R4
        '{8'h11, 4'b1101, 1'b1, 4'b0010, 2'b00},  // R4
        '{8'h22, 4'b1011, 1'b1, 4'b0100, 2'b00},  // R4
        '{8'h23, 4'b0111, 1'b1, 4'b1000, 2'b00},  // R4
        '{8'h80, 4'b1100, 1'b1, 4'b0011, 2'b01},  // R5
        '{8'h82, 4'b0011, 1'b1, 4'b1100, 2'b01},  // R5
        '{8'h80, 4'b0000, 1'b1, 4'b1111, 2'b01},  // R5
        '{8'h81, 4'b1101, 1'b1, 4'b0010, 2'b01},  // R4
        '{8'h84, 4'b1100, 1'b1, 4'b0011, 2'b10},  // R7
        '{8'h86, 4'b0011, 1'b1, 4'b1100, 2'b10},  // R7
        '{8'h85, 4'b0111, 1'b1, 4'b1000, 2'b10},  // R7
        '{8'h10, 4'b1100, 1'b0, 4'b0000, 2'b00},  // R7 reg 16-bit
        '{8'h84, 4'b0000, 1'b0, 4'b0000, 2'b10},  // R7 cnt 32-bit
        '{8'h81, 4'b1110, 1'b0, 4'b0000, 2'b01},  // R6 A0 mismatch
        '{8'h80, 4'b0101, 1'b0, 4'b0000, 2'b01},  // R6 bad pattern
        '{8'h81, 4'b0000, 1'b0, 4'b0000, 2'b01}   // R6 A0 mismatch
    };

    function automatic logic [31:0] mask_of(input logic [3:0] l);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{l[i]}};
        return m;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic latch_addr(input logic [7:0] a);
        @(negedge clk);
        ad_lo_i = a;
        ale     = 1'b1;
        repeat (3) @(negedge clk);
        ale     = 1'b0;
        ad_lo_i = ~a;                       // later AD changes must not matter (R1)
    endtask

    task automatic access(input logic [7:0] a, input logic [3:0] be, input bit is_rd,
                          input bit is_wr, input bit ok, input logic [3:0] lanes,
                          input logic [1:0] tgt, input bit sets_err, input string req);
        bit drive;
        drive = is_rd && !is_wr && ok;
        latch_addr(a);
        cs_n = 1'b0; rd_n = !is_rd; wr_n = !is_wr; be_n = be;
        repeat (2) @(negedge clk);
        check({req, " R9 rd_pulse"}, rd_pulse, drive);
        check({req, " R9 wr_pulse"}, wr_pulse, is_wr && !is_rd && ok);
        check({req, " R1 acc_addr"}, acc_addr, a);
        check({req, " acc_lanes"}, acc_lanes, ok ? lanes : 4'b0);
        check({req, " R7 acc_tgt"}, acc_tgt, tgt);
        if (sets_err) err_exp = 1;
        @(negedge clk);
        check({req, " R9 pulse gone"}, {rd_pulse, wr_pulse}, 2'b00);
        check({req, " R8 ad_oe"}, ad_oe, drive ? lanes : 4'b0);
        check({req, " R8 ad_o"}, ad_o, drive ? (rdata_i & mask_of(lanes)) : 32'h0);
        check({req, " R6 err_o"}, err_o, err_exp);
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; be_n = 4'hF;
        repeat (2) @(negedge clk);
        check({req, " R8 oe hold"}, ad_oe, drive ? lanes : 4'b0);
        @(negedge clk);
        check({req, " R8 oe release"}, ad_oe, 4'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        check("R11 oe in reset", ad_oe, 4'b0);
        check("R11 err in reset", err_o, 1'b0);
        check("R11 pulses in reset", {rd_pulse, wr_pulse}, 2'b00);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 oe after reset", ad_oe, 4'b0);
        check("R11 err after reset", err_o, 1'b0);

        // R3: idle pattern
        access(8'h10, 4'b1111, 1, 0, 0, 4'b0, 2'b00, 0, "R3 idle read");

        // R9: write pulse, no drive
        access(8'h23, 4'b0111, 0, 1, 1, 4'b1000, 2'b00, 0, "R9 write");

        // R2: ALE and read arrive together; stale 0x10 register address would reject 16-bit
        latch_addr(8'h10);
        @(negedge clk);
        ad_lo_i = 8'h84; ale = 1'b1; cs_n = 1'b0; rd_n = 1'b0; be_n = 4'b1100;
        repeat (2) @(negedge clk);
        check("R2 rd_pulse", rd_pulse, 1'b1);
        check("R2 acc_addr", acc_addr, 8'h84);
        check("R2 acc_tgt", acc_tgt, 2'b10);
        check("R2 acc_lanes", acc_lanes, 4'b0011);
        ale = 1'b0; cs_n = 1'b1; rd_n = 1'b1; be_n = 4'hF;
        repeat (4) @(negedge clk);
        check("R2 no error", err_o, 1'b0);

        // Table walk: R4, R5, R6, R7
        for (int i = 0; i < NV; i++) begin
            rdata_i = 32'h1122_3344 ^ (32'h0101_0101 * i);
            access(VECS[i].addr, VECS[i].be, 1, 0, VECS[i].ok, VECS[i].lanes,
                   VECS[i].tgt, !VECS[i].ok, "table");
        end

        // R10: read and write together
        access(8'h11, 4'b1101, 1, 1, 0, 4'b0010, 2'b00, 1, "R10 rd+wr");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule